// File: doc/BRIEF.md
# Host Command Transfer Sequencer

This block is a bus master that sends one fixed command to a byte-wide, FIFO-style security coprocessor and collects its reply. After a start pulse it makes sure the host owns locality 0 on the device. It then makes sure the device is ready to accept a command, and forces it ready with an abort write if it is not. It streams the command into the device's data port in bursts whose size it learns from the device's live burst count, writes the final byte on its own, and checks that the device no longer expects data. It then issues go and drains the response.

The block talks to the device over a simple single-cycle register bus. A read returns data in the same cycle it is issued, and at most one access is made per clock. Every wait on the device is a poll loop bounded by a programmable limit. When that limit runs out, the sequence ends with an error and a code that names the stuck phase. The command is a 10-byte request to save device state, generated inside the block. The response can be drained fully or cut short once the header has arrived.

Top module: `cmd_xfer_seq`

## Requirements
- R1: A start pulse seen while a sequence is running is ignored. `done` is high for exactly one cycle at the end of every sequence, whether it succeeded or failed, and no bus access happens in the cycle after `done`.
- R2: The sequence first reads the access register at offset 0x00. If bits 0x80 (valid) and 0x20 (active) are not both set, it writes 0x02 (request) to that register once and polls it until both bits are set. If both are already set, no request is written.
- R3: The status register is at offset 0x18, with ready at bit 0x40. If ready is clear, the sequencer writes 0x40 to the status register and polls until ready is set. No data byte is written while the device is not ready.
- R4: The burst count is read as a low byte at offset 0x19 followed in the next cycle by a high byte at offset 0x1A. A zero count is re-read until it is nonzero.
- R5: All command bytes except the last are written to the data port at offset 0x24. Within one burst, no more bytes are written than the burst count allows. After each burst the sequencer polls status until bits 0x80 and 0x08 (expect) are both set.
- R6: After the last byte the sequencer polls status for 0x80. If 0x08 is then still set, it ends with error code 6 and does not write go. Otherwise it writes 0x20 (go) to status, and only after all command bytes have been written.
- R7: The bytes written, in order, are 00 C1 00 00 00 0A 00 00 00 98.
- R8: For the response, the sequencer polls status until 0x10 (available) and 0x80 are both set. It then reads the data port up to the burst count per round, and never more than RESP_MAX bytes in total. When `headerOnly` was high at start, it stops at the end of the first round that leaves at least 6 bytes collected. `respCount` gives the number of bytes read.
- R9: A poll fails with an error when pollLimit+1 consecutive polls of the same condition fail. `err` then rises with `done`, and `errCode` is 1 for locality, 2 for ready, 3 for a zero burst count, 4 for the expect wait, 5 for the valid wait, 6 for expect still set, and 7 for the available wait. On success, `err` is 0 and `errCode` is 0.
- R10: `busRd` and `busWr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sequence (pulse) |
| headerOnly | input | 1 | Stop the response once the header is complete; sampled at start |
| pollLimit | input | POLL_W | Failed polls allowed before a timeout |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busAddr | output | ADDR_W | Register offset |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid in the cycle of the read |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last sequence failed |
| errCode | output | 3 | Phase that failed |
| respCount | output | RESP_W | Response bytes collected |

## Verification
The bench keeps the default RESP_MAX of 10, so a full drain and a header-only stop can both be seen in the same ten-byte reply. It uses burst counts of 1, 3, 4, 16 and 0, which cover a one-byte write burst, a header stop at exactly 6 and at 8, a burst larger than the whole command, and the zero-count timeout. A pollLimit of 20 keeps every timeout short enough that the number of polls before an error can be counted exactly. Device delays well above that limit reach each error code, and small delays exercise the request and abort paths.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  localparam int CMD_LEN = 10;
  localparam int HDR_MIN = 6;

  localparam logic [7:0] B_VALID  = 8'h80;
  localparam logic [7:0] B_ACTIVE = 8'h20;
  localparam logic [7:0] B_REQ    = 8'h02;
  localparam logic [7:0] B_READY  = 8'h40;
  localparam logic [7:0] B_GO     = 8'h20;
  localparam logic [7:0] B_AVAIL  = 8'h10;
  localparam logic [7:0] B_EXPECT = 8'h08;

  typedef enum logic [4:0] {
    S_IDLE, S_ACC_RD, S_ACC_REQ, S_ACC_POLL, S_STS_RD, S_ABORT, S_RDY_POLL,
    S_WB_LO, S_WB_HI, S_WR_DATA, S_EXP_POLL, S_WR_LAST, S_VAL_POLL, S_GO,
    S_AV_POLL, S_RB_LO, S_RB_HI, S_RD_DATA, S_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    E_NONE, E_LOCALITY, E_READY, E_BURST, E_EXPECT_WAIT, E_VALID_WAIT,
    E_EXPECT_STUCK, E_AVAIL_WAIT
  } errCode_t;

  typedef struct packed {
    logic clrAll;
    logic clrPoll;
    logic incPoll;
    logic ldBurstLo;
    logic ldBurst;
    logic decBurst;
    logic incIdx;
    logic incResp;
  } dpStrobe_t;

  // Save-state request: tag, length, ordinal, big-endian
  function automatic logic [7:0] cmdRom(input logic [3:0] i);
    case (i)
      4'd1:    cmdRom = 8'hC1;
      4'd5:    cmdRom = 8'h0A;
      4'd9:    cmdRom = 8'h98;
      default: cmdRom = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cxs_datapath.sv
module cxs_datapath
  import cxs_pkg::*;
#(
  parameter int POLL_W = 16,
  parameter int RESP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        busRdata,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              pollExpired,
  output logic              burstZero,
  output logic              burstLast,
  output logic [3:0]        idx,
  output logic [RESP_W-1:0] respCount,
  output logic [7:0]        cmdByte
);
  localparam int BURST_W = 16;

  logic [POLL_W-1:0]  pollCnt;
  logic [7:0]         burstLo;
  logic [BURST_W-1:0] burstRem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt   <= '0;
      burstLo   <= '0;
      burstRem  <= '0;
      idx       <= '0;
      respCount <= '0;
    end else begin
      if (stb.clrAll || stb.clrPoll) pollCnt <= '0;
      else if (stb.incPoll)          pollCnt <= pollCnt + 1'b1;
      if (stb.ldBurstLo) burstLo <= busRdata;
      if (stb.ldBurst)       burstRem <= {busRdata, burstLo};
      else if (stb.decBurst) burstRem <= burstRem - 1'b1;
      if (stb.clrAll)      idx <= '0;
      else if (stb.incIdx) idx <= idx + 1'b1;
      if (stb.clrAll)       respCount <= '0;
      else if (stb.incResp) respCount <= respCount + 1'b1;
    end
  end

  assign pollExpired = (pollCnt == pollLimit);
  assign burstZero   = ({busRdata, burstLo} == '0);
  assign burstLast   = (burstRem == BURST_W'(1));
  assign cmdByte     = cmdRom(idx);
endmodule

// File: rtl/cxs_control.sv
module cxs_control
  import cxs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                RESP_W    = 4,
  parameter int                RESP_MAX  = 10,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              headerOnly,
  input  logic [7:0]        busRdata,
  input  logic              pollExpired,
  input  logic              burstZero,
  input  logic              burstLast,
  input  logic [3:0]        idx,
  input  logic [RESP_W-1:0] respCount,
  input  logic [7:0]        cmdByte,
  output dpStrobe_t         stb,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              done,
  output logic              err,
  output logic [2:0]        errCode
);
  localparam logic [ADDR_W-1:0] BLO_ADDR = ADDR_W'(STS_ADDR + 1);
  localparam logic [ADDR_W-1:0] BHI_ADDR = ADDR_W'(STS_ADDR + 2);

  seqState_t st, nxt;
  errCode_t  failCode, codeQ;
  logic      failNow, keepPoll, hdrQ, errQ;
  logic [RESP_W-1:0] newCnt;

  assign newCnt = respCount + 1'b1;

  always_comb begin
    nxt = st; stb = '0; busRd = 1'b0; busWr = 1'b0;
    busAddr = '0; busWdata = '0; failNow = 1'b0; failCode = E_NONE; keepPoll = 1'b0;
    case (st)
      S_IDLE: if (start) begin nxt = S_ACC_RD; stb.clrAll = 1'b1; end
      S_ACC_RD: begin
        busRd = 1'b1; busAddr = ACC_ADDR;
        nxt = ((busRdata & (B_VALID | B_ACTIVE)) == (B_VALID | B_ACTIVE)) ? S_STS_RD : S_ACC_REQ;
      end
      S_ACC_REQ: begin busWr = 1'b1; busAddr = ACC_ADDR; busWdata = B_REQ; nxt = S_ACC_POLL; end
      S_ACC_POLL: begin
        busRd = 1'b1; busAddr = ACC_ADDR;
        if ((busRdata & (B_VALID | B_ACTIVE)) == (B_VALID | B_ACTIVE)) nxt = S_STS_RD;
        else if (pollExpired) begin failNow = 1'b1; failCode = E_LOCALITY; end
        else stb.incPoll = 1'b1;
      end
      S_STS_RD: begin
        busRd = 1'b1; busAddr = STS_ADDR;
        nxt = (busRdata & B_READY) != 0 ? S_WB_LO : S_ABORT;
      end
      S_ABORT: begin busWr = 1'b1; busAddr = STS_ADDR; busWdata = B_READY; nxt = S_RDY_POLL; end
      S_RDY_POLL: begin
        busRd = 1'b1; busAddr = STS_ADDR;
        if ((busRdata & B_READY) != 0) nxt = S_WB_LO;
        else if (pollExpired) begin failNow = 1'b1; failCode = E_READY; end
        else stb.incPoll = 1'b1;
      end
      S_WB_LO, S_RB_LO: begin
        busRd = 1'b1; busAddr = BLO_ADDR; stb.ldBurstLo = 1'b1; keepPoll = 1'b1;
        nxt = (st == S_WB_LO) ? S_WB_HI : S_RB_HI;
      end
      S_WB_HI, S_RB_HI: begin
        busRd = 1'b1; busAddr = BHI_ADDR;
        if (!burstZero) begin
          stb.ldBurst = 1'b1;
          nxt = (st == S_WB_HI) ? S_WR_DATA : S_RD_DATA;
        end else if (pollExpired) begin failNow = 1'b1; failCode = E_BURST; end
        else begin
          stb.incPoll = 1'b1; keepPoll = 1'b1;
          nxt = (st == S_WB_HI) ? S_WB_LO : S_RB_LO;
        end
      end
      S_WR_DATA: begin
        busWr = 1'b1; busAddr = DATA_ADDR; busWdata = cmdByte;
        stb.incIdx = 1'b1; stb.decBurst = 1'b1;
        if (burstLast || idx == 4'(CMD_LEN - 2)) nxt = S_EXP_POLL;
      end
      S_EXP_POLL: begin
        busRd = 1'b1; busAddr = STS_ADDR;
        if ((busRdata & (B_VALID | B_EXPECT)) == (B_VALID | B_EXPECT))
          nxt = (idx == 4'(CMD_LEN - 1)) ? S_WR_LAST : S_WB_LO;
        else if (pollExpired) begin failNow = 1'b1; failCode = E_EXPECT_WAIT; end
        else stb.incPoll = 1'b1;
      end
      S_WR_LAST: begin busWr = 1'b1; busAddr = DATA_ADDR; busWdata = cmdByte; nxt = S_VAL_POLL; end
      S_VAL_POLL: begin
        busRd = 1'b1; busAddr = STS_ADDR;
        if ((busRdata & B_VALID) != 0) begin
          if ((busRdata & B_EXPECT) != 0) begin failNow = 1'b1; failCode = E_EXPECT_STUCK; end
          else nxt = S_GO;
        end else if (pollExpired) begin failNow = 1'b1; failCode = E_VALID_WAIT; end
        else stb.incPoll = 1'b1;
      end
      S_GO: begin busWr = 1'b1; busAddr = STS_ADDR; busWdata = B_GO; nxt = S_AV_POLL; end
      S_AV_POLL: begin
        busRd = 1'b1; busAddr = STS_ADDR;
        if ((busRdata & (B_VALID | B_AVAIL)) == (B_VALID | B_AVAIL)) nxt = S_RB_LO;
        else if (pollExpired) begin failNow = 1'b1; failCode = E_AVAIL_WAIT; end
        else stb.incPoll = 1'b1;
      end
      S_RD_DATA: begin
        busRd = 1'b1; busAddr = DATA_ADDR; stb.incResp = 1'b1; stb.decBurst = 1'b1;
        if (burstLast || newCnt == RESP_W'(RESP_MAX)) begin
          if (newCnt == RESP_W'(RESP_MAX) || (hdrQ && newCnt >= RESP_W'(HDR_MIN))) nxt = S_DONE;
          else nxt = S_AV_POLL;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (failNow) nxt = S_DONE;
    if (nxt != st && !keepPoll) stb.clrPoll = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE; errQ <= 1'b0; codeQ <= E_NONE; hdrQ <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) hdrQ <= headerOnly;
      if (nxt == S_DONE && st != S_DONE) begin
        errQ <= failNow; codeQ <= failCode;
      end
    end
  end

  assign done    = (st == S_DONE);
  assign err     = errQ;
  assign errCode = codeQ;
endmodule

// File: rtl/cmd_xfer_seq.sv
module cmd_xfer_seq
  import cxs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                POLL_W    = 16,
  parameter int                RESP_MAX  = 10,
  parameter logic [ADDR_W-1:0] ACC_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h24,
  localparam int               RESP_W    = $clog2(RESP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              headerOnly,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata,
  output logic              done,
  output logic              err,
  output logic [2:0]        errCode,
  output logic [RESP_W-1:0] respCount
);
  dpStrobe_t  stb;
  logic       pollExpired, burstZero, burstLast;
  logic [3:0] idx;
  logic [7:0] cmdByte;

  cxs_control #(
    .ADDR_W(ADDR_W), .RESP_W(RESP_W), .RESP_MAX(RESP_MAX),
    .ACC_ADDR(ACC_ADDR), .STS_ADDR(STS_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .headerOnly(headerOnly),
    .busRdata(busRdata), .pollExpired(pollExpired), .burstZero(burstZero),
    .burstLast(burstLast), .idx(idx), .respCount(respCount), .cmdByte(cmdByte),
    .stb(stb), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .done(done), .err(err), .errCode(errCode)
  );

  cxs_datapath #(.POLL_W(POLL_W), .RESP_W(RESP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busRdata(busRdata),
    .pollLimit(pollLimit), .pollExpired(pollExpired), .burstZero(burstZero),
    .burstLast(burstLast), .idx(idx), .respCount(respCount), .cmdByte(cmdByte)
  );
endmodule

// File: rtl/cxs_checker.sv
module cxs_checker
  import cxs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 8'h18,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              done,
  input logic              err,
  input logic [2:0]        errCode
);
  logic [7:0] wrCnt;

  always_ff @(posedge clk) begin
    if (!rstN || done) wrCnt <= '0;
    else if (busWr && busAddr == DATA_ADDR) wrCnt <= wrCnt + 1'b1;
  end

  p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_quiet_after_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !(busRd || busWr));
  p_burst_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(STS_ADDR + 1)) |=> (busRd && busAddr == ADDR_W'(STS_ADDR + 2)));
  p_go_after_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STS_ADDR && busWdata == B_GO) |-> (wrCnt == 8'(CMD_LEN)));
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);
  p_code_on_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (errCode != 3'd0));
endmodule

bind cmd_xfer_seq cxs_checker #(
  .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .done(done), .err(err), .errCode(errCode)
);

// File: tb/tb_cmd_xfer_seq.sv
module tb_cmd_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RESP_W = 4;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, headerOnly = 1'b0;
  logic [15:0] pollLimit = 16'd20;
  logic busRd, busWr, done, err;
  logic [7:0] busAddr, busWdata, busRdata;
  logic [2:0] errCode;
  logic [RESP_W-1:0] respCount;

  int checks = 0, fails = 0, cycles = 0;

  cmd_xfer_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .headerOnly(headerOnly),
    .pollLimit(pollLimit), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .done(done), .err(err),
    .errCode(errCode), .respCount(respCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural device model
  logic [7:0] expCmd [0:9] = '{8'h00,8'hC1,8'h00,8'h00,8'h00,8'h0A,8'h00,8'h00,8'h00,8'h98};
  logic [7:0] respMem [0:9] = '{8'h00,8'hC4,8'h00,8'h00,8'h00,8'h0A,8'h00,8'h00,8'h00,8'h00};
  logic [7:0] rxMem [0:31];
  bit devActive, devReady, respReady, goSeen;
  int grantCnt, readyCnt, availCnt, grantDelay, readyDelay, availDelay;
  int devBurst, devExpLen, rxCnt, respIdx, burstUsed;
  int accReads, reqWrites, abortWrites, doneCnt;
  bit opRd, opWr; logic [7:0] opAddr, opData;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always_comb begin
    busRdata = 8'h00;
    case (busAddr)
      8'h00: busRdata = {1'b1, 1'b0, devActive, 5'b0};
      8'h18: busRdata = {1'b1, devReady, 1'b0, respReady && respIdx < 10,
                         rxCnt > 0 && rxCnt < devExpLen, 3'b0};
      8'h19: busRdata = devBurst[7:0];
      8'h1A: busRdata = devBurst[15:8];
      8'h24: busRdata = respMem[respIdx < 10 ? respIdx : 0];
      default: busRdata = 8'h00;
    endcase
  end

  always @(negedge clk) begin
    opRd = busRd; opWr = busWr; opAddr = busAddr; opData = busWdata;
    if (rstN) begin
      if (busRd || busWr) check(!(busRd && busWr), "R10", int'(busRd && busWr), 0);
      if (busWr && busAddr == 8'h24) begin
        check(devReady, "R3", int'(devReady), 1);
        if (rxCnt < 9) check(burstUsed < devBurst, "R5", burstUsed, devBurst - 1);
      end
      if (busRd && busAddr == 8'h24) begin
        check(respReady, "R8", int'(respReady), 1);
        check(burstUsed < devBurst, "R8", burstUsed, devBurst - 1);
      end
      if (busWr && busAddr == 8'h18 && busWdata == 8'h20) check(rxCnt == 10, "R6", rxCnt, 10);
      if (done) doneCnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (grantCnt > 0) begin grantCnt <= grantCnt - 1; if (grantCnt == 1) devActive <= 1'b1; end
    if (readyCnt > 0) begin readyCnt <= readyCnt - 1; if (readyCnt == 1) devReady <= 1'b1; end
    if (availCnt > 0) begin availCnt <= availCnt - 1; if (availCnt == 1) respReady <= 1'b1; end
    if (rstN && opRd) begin
      if (opAddr == 8'h00) accReads <= accReads + 1;
      if (opAddr == 8'h1A) burstUsed <= 0;
      if (opAddr == 8'h24) begin respIdx <= respIdx + 1; burstUsed <= burstUsed + 1; end
    end
    if (rstN && opWr) begin
      if (opAddr == 8'h00 && opData == 8'h02) begin reqWrites <= reqWrites + 1; grantCnt <= grantDelay; end
      if (opAddr == 8'h18 && opData == 8'h40) begin abortWrites <= abortWrites + 1; readyCnt <= readyDelay; end
      if (opAddr == 8'h18 && opData == 8'h20) begin goSeen <= 1'b1; availCnt <= availDelay; end
      if (opAddr == 8'h24) begin rxMem[rxCnt] <= opData; rxCnt <= rxCnt + 1; burstUsed <= burstUsed + 1; end
    end
  end

  task automatic setDev(input bit act, input int gD, input bit rdy, input int rD,
                        input int burst, input int expLen, input int aD);
    devActive = act; grantDelay = gD; devReady = rdy; readyDelay = rD;
    devBurst = burst; devExpLen = expLen; availDelay = aD;
    grantCnt = 0; readyCnt = 0; availCnt = 0; respReady = 1'b0; goSeen = 1'b0;
    rxCnt = 0; respIdx = 0; burstUsed = 0; accReads = 0; reqWrites = 0;
    abortWrites = 0; doneCnt = 0;
  endtask

  task automatic runSeq(input bit hdr, input bit poke, input string tag,
                        input int expErr, input int expCode, input int expResp, input bit expGo);
    int waitCnt = 0;
    headerOnly = hdr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && waitCnt < 5000) begin
      if (poke && waitCnt == 6) start = 1'b1; else start = 1'b0;
      @(negedge clk); waitCnt++;
    end
    start = 1'b0;
    check(done, {tag, " R1 done seen"}, int'(done), 1);
    check(int'(err) == expErr, {tag, " R9 err"}, int'(err), expErr);
    check(int'(errCode) == expCode, {tag, " R9 code"}, int'(errCode), expCode);
    check(int'(respCount) == expResp, {tag, " R8 respCount"}, int'(respCount), expResp);
    check(goSeen == expGo, {tag, " R6 go"}, int'(goSeen), int'(expGo));
    if (expGo) for (int i = 0; i < 10; i++)
      check(rxMem[i] == expCmd[i], {tag, " R7 byte"}, int'(rxMem[i]), int'(expCmd[i]));
    @(negedge clk);
    check(!done, {tag, " R1 one-cycle done"}, int'(done), 0);
    repeat (20) @(negedge clk);
    check(doneCnt == 1, {tag, " R1 single done"}, doneCnt, 1);
  endtask

  initial begin
    setDev(1, 0, 1, 0, 4, 10, 2);
    repeat (3) @(negedge clk);
    check(!busRd && !busWr && !done && !err, "reset R1", int'({busRd, busWr, done, err}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: already active, no request; header-only with burst 4 stops at 8
    setDev(1, 0, 1, 0, 4, 10, 2);
    runSeq(1, 0, "s1", 0, 0, 8, 1);
    check(reqWrites == 0, "s1 R2 no request", reqWrites, 0);
    check(abortWrites == 0, "s1 R3 no abort", abortWrites, 0);

    // R2/R3 paths, burst 1, full drain, start while busy
    setDev(0, 3, 0, 5, 1, 10, 3);
    runSeq(0, 1, "s2", 0, 0, 10, 1);
    check(reqWrites == 1, "s2 R2 request", reqWrites, 1);
    check(abortWrites == 1, "s2 R3 abort", abortWrites, 1);

    // R8 header stop at exactly 6
    setDev(1, 0, 1, 0, 3, 10, 1);
    runSeq(1, 0, "s3", 0, 0, 6, 1);

    // R5 burst larger than command, R8 capped at RESP_MAX
    setDev(1, 0, 1, 0, 16, 10, 1);
    runSeq(1, 0, "s4", 0, 0, 10, 1);

    // R9 locality timeout, exact poll count
    setDev(0, 1000, 1, 0, 4, 10, 1);
    runSeq(0, 0, "s5", 1, 1, 0, 0);
    check(accReads == 22, "s5 R9 poll count", accReads, 22);
    check(rxCnt == 0, "s5 R2 no data", rxCnt, 0);

    setDev(1, 0, 0, 1000, 4, 10, 1);
    runSeq(0, 0, "s6", 1, 2, 0, 0);
    check(rxCnt == 0, "s6 R3 no data", rxCnt, 0);

    setDev(1, 0, 1, 0, 0, 10, 1);
    runSeq(0, 0, "s7", 1, 3, 0, 0);

    setDev(1, 0, 1, 0, 4, 2, 1);
    runSeq(0, 0, "s8", 1, 4, 0, 0);
    check(rxCnt == 4, "s8 R5 burst written", rxCnt, 4);

    setDev(1, 0, 1, 0, 4, 11, 1);
    runSeq(0, 0, "s9", 1, 6, 0, 0);
    check(rxCnt == 10, "s9 R6 all bytes", rxCnt, 10);

    setDev(1, 0, 1, 0, 4, 10, 1000);
    runSeq(0, 0, "s10", 1, 7, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule